// File: doc/BRIEF.md
# DMA Address Window Decoder

This block sits on the outgoing address path of a DMA engine. It routes each request address onto one of up to four memory chip-select windows. A small register interface programs the decoder. One control word holds a per-window enable bit and a per-window access field. Each window also has a base register and a size-mask register. A separate override register can force the upper address bits to a fixed page.

Every request is compared against all windows in parallel. A window matches when the unmasked upper address bits equal its base. If several windows match, the lowest-numbered one wins. The winning window's access field is then checked against the request direction.

One clock after the request, the block reports exactly one of three outcomes:
- hit, with the winning window and its chip-select attribute;
- access error, with the winning window;
- miss.

Top module: `dma_win_decode`

## Requirements
- R1: After reset every register reads back as zero, and no response is reported.
- R2: Register addresses are 0 for control, 1 for override, 2+2i for the base of window i and 3+2i for the mask of window i. The stored fields read back at their write positions:
  - control: enable bit i at bit i, and the access field of window i at bits [17+2i:16+2i];
  - base: page at [31:16] and attribute at [11:8];
  - mask: [31:16];
  - override: page at [31:16] and enable at bit 0.
  All other bits read as zero.
- R3: A window takes part in decoding only while its enable bit is set.
- R4: A request address matches window i when (addr[31:16] & ~mask[31:16]) equals (base[31:16] & ~mask[31:16]). A mask bit of 1 therefore means "don't care".
- R5: When several enabled windows match, the lowest-numbered window is chosen.
- R6: When no enabled window matches, the miss flag is set. In that case the window index and the attribute outputs are zero.
- R7: Access field bit 0 grants read and bit 1 grants write, so the value 3 grants both. A request whose direction is not granted by the chosen window raises the error flag in place of a hit. It reports the chosen window index, an attribute of zero, and does not fall through to a later window.
- R8: On a hit the block reports the chosen window index and that window's 4-bit attribute. The attribute is typically 0xE, 0xD, 0xB or 0x7, selecting CS0 to CS3 one-hot-low.
- R9: While override bit 0 is set, the override page replaces addr[31:16] before matching. Clearing the register to zero restores normal decoding.
- R10: Each request cycle yields a response exactly one clock later, with exactly one of hit, miss and error set. Back-to-back requests produce back-to-back responses.
- R11: Writes to register addresses above the last window register change no register, and reads from such addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address (write and combinational read) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| req_valid_i | input | 1 | Request valid |
| req_write_i | input | 1 | Request direction, 1 = write |
| req_addr_i | input | 32 | Request address |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_hit_o | output | 1 | Request decoded to a permitted window |
| rsp_miss_o | output | 1 | No enabled window matched |
| rsp_err_o | output | 1 | Chosen window forbids this direction |
| rsp_win_o | output | 2 | Chosen window index |
| rsp_attr_o | output | 4 | Chip-select attribute of the chosen window |

## Verification
The hardest situation to reach is a request that matches two or more windows, where the lower window also forbids the request direction. Only that case shows that priority is settled before permission and that the error does not leak to a permitted higher window.

The stimulus gets there in steps:
1. It reprograms one window so that it sits inside another window's range.
2. It loads mixed access fields (read-only, write-only, none, full).
3. It sends reads and writes into the overlap.
4. It disables the lower window and repeats, to show the higher one then takes over.

The override page is exercised in a similar way. Override is enabled with a page that only a higher window covers, and is then switched off by writing a value with only its enable bit cleared.

// File: rtl/dwd_pkg.sv
package dwd_pkg;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned PAGE_LSB = 16;
  localparam int unsigned PAGE_W   = ADDR_W - PAGE_LSB;
  localparam int unsigned ATTR_LSB = 8;
  localparam int unsigned ATTR_W   = 4;
  localparam int unsigned ACC_LSB  = 16;
  localparam int unsigned ACC_W    = 2;
  localparam int unsigned ACC_RD   = 0;
  localparam int unsigned ACC_WR   = 1;
  localparam int unsigned OVR_EN   = 0;

  typedef enum int unsigned {
    RA_CTRL = 0,
    RA_OVR  = 1,
    RA_WIN0 = 2
  } reg_idx_e;

  typedef struct packed {
    logic hit;
    logic miss;
    logic err;
  } rsp_flags_t;
endpackage

// File: rtl/dwd_regs.sv
module dwd_regs
  import dwd_pkg::*;
#(
  parameter int unsigned N_WIN  = 4,
  parameter int unsigned REG_AW = 4
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_i,
  input  logic [REG_AW-1:0]                addr_i,
  input  logic [REG_W-1:0]                 wdata_i,
  output logic [REG_W-1:0]                 rdata_o,
  output logic [N_WIN-1:0]                 en_o,
  output logic [N_WIN-1:0][ACC_W-1:0]      acc_o,
  output logic [N_WIN-1:0][PAGE_W-1:0]     base_o,
  output logic [N_WIN-1:0][PAGE_W-1:0]     mask_o,
  output logic [N_WIN-1:0][ATTR_W-1:0]     attr_o,
  output logic                             ovr_en_o,
  output logic [PAGE_W-1:0]                ovr_page_o
);
  localparam int unsigned N_REGS = RA_WIN0 + 2 * N_WIN;

  logic [N_WIN-1:0]             en_q;
  logic [N_WIN-1:0][ACC_W-1:0]  acc_q;
  logic [N_WIN-1:0][PAGE_W-1:0] base_q;
  logic [N_WIN-1:0][PAGE_W-1:0] mask_q;
  logic [N_WIN-1:0][ATTR_W-1:0] attr_q;
  logic                         ovr_en_q;
  logic [PAGE_W-1:0]            ovr_page_q;

  logic ctrl_we, ovr_we;
  assign ctrl_we = wr_i && (addr_i == REG_AW'(RA_CTRL));
  assign ovr_we  = wr_i && (addr_i == REG_AW'(RA_OVR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      acc_q <= '0;
    end else if (ctrl_we) begin
      en_q <= wdata_i[N_WIN-1:0];
      for (int i = 0; i < N_WIN; i++)
        acc_q[i] <= wdata_i[ACC_LSB + ACC_W*i +: ACC_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_en_q   <= 1'b0;
      ovr_page_q <= '0;
    end else if (ovr_we) begin
      ovr_en_q   <= wdata_i[OVR_EN];
      ovr_page_q <= wdata_i[REG_W-1 -: PAGE_W];
    end
  end

  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    logic base_we, mask_we;
    assign base_we = wr_i && (addr_i == REG_AW'(RA_WIN0 + 2*g));
    assign mask_we = wr_i && (addr_i == REG_AW'(RA_WIN0 + 2*g + 1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[g] <= '0;
        attr_q[g] <= '0;
      end else if (base_we) begin
        base_q[g] <= wdata_i[REG_W-1 -: PAGE_W];
        attr_q[g] <= wdata_i[ATTR_LSB +: ATTR_W];
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      mask_q[g] <= '0;
      else if (mask_we) mask_q[g] <= wdata_i[REG_W-1 -: PAGE_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == REG_AW'(RA_CTRL)) begin
      rdata_o[N_WIN-1:0] = en_q;
      for (int i = 0; i < N_WIN; i++)
        rdata_o[ACC_LSB + ACC_W*i +: ACC_W] = acc_q[i];
    end
    if (addr_i == REG_AW'(RA_OVR)) begin
      rdata_o[REG_W-1 -: PAGE_W] = ovr_page_q;
      rdata_o[OVR_EN]            = ovr_en_q;
    end
    for (int i = 0; i < N_WIN; i++) begin
      if (addr_i == REG_AW'(RA_WIN0 + 2*i)) begin
        rdata_o[REG_W-1 -: PAGE_W]   = base_q[i];
        rdata_o[ATTR_LSB +: ATTR_W]  = attr_q[i];
      end
      if (addr_i == REG_AW'(RA_WIN0 + 2*i + 1))
        rdata_o[REG_W-1 -: PAGE_W] = mask_q[i];
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  assign en_o       = en_q;
  assign acc_o      = acc_q;
  assign base_o     = base_q;
  assign mask_o     = mask_q;
  assign attr_o     = attr_q;
  assign ovr_en_o   = ovr_en_q;
  assign ovr_page_o = ovr_page_q;

  a_r2_ctrl_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we |=> en_q == $past(wdata_i[N_WIN-1:0]));

  a_r2_ovr_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_we |=> ovr_page_q == $past(wdata_i[REG_W-1 -: PAGE_W]));

  a_r11_unmapped_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (int'(addr_i) >= N_REGS)) |=>
      ($stable(en_q) && $stable(acc_q) && $stable(base_q) && $stable(mask_q) &&
       $stable(attr_q) && $stable(ovr_en_q) && $stable(ovr_page_q)));

  a_r11_unmapped_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(addr_i) >= N_REGS) |-> rdata_o == '0);
endmodule

// File: rtl/dwd_win_match.sv
module dwd_win_match
  import dwd_pkg::*;
#(
  parameter int unsigned N_WIN = 4
) (
  input  logic [N_WIN-1:0]             en_i,
  input  logic [N_WIN-1:0][PAGE_W-1:0] base_i,
  input  logic [N_WIN-1:0][PAGE_W-1:0] mask_i,
  input  logic [PAGE_W-1:0]            page_i,
  output logic [N_WIN-1:0]             hit_o
);
  for (genvar g = 0; g < N_WIN; g++) begin : g_cmp
    // mask bit set = don't care
    assign hit_o[g] = en_i[g] &&
                      ((page_i & ~mask_i[g]) == (base_i[g] & ~mask_i[g]));
  end
endmodule

// File: rtl/dwd_lowest_pick.sv
module dwd_lowest_pick #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o
);
  logic found;

  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !found) begin
        gnt_o[i] = 1'b1;
        idx_o    = IW'(i);
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_win_decode.sv
module dma_win_decode
  import dwd_pkg::*;
#(
  parameter int unsigned N_WIN  = 4,
  parameter int unsigned REG_AW = 4,
  localparam int unsigned WIN_IW = (N_WIN > 1) ? $clog2(N_WIN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_miss_o,
  output logic              rsp_err_o,
  output logic [WIN_IW-1:0] rsp_win_o,
  output logic [ATTR_W-1:0] rsp_attr_o
);
  logic [N_WIN-1:0]             en;
  logic [N_WIN-1:0][ACC_W-1:0]  acc;
  logic [N_WIN-1:0][PAGE_W-1:0] base, mask;
  logic [N_WIN-1:0][ATTR_W-1:0] attr;
  logic                         ovr_en;
  logic [PAGE_W-1:0]            ovr_page, page;
  logic [N_WIN-1:0]             match, gnt;
  logic [WIN_IW-1:0]            idx;
  logic [ACC_W-1:0]             acc_sel;
  logic                         any, perm_ok;
  rsp_flags_t                   flags_d, flags_q;
  logic                         valid_q;
  logic [WIN_IW-1:0]            win_q;
  logic [ATTR_W-1:0]            attr_q;
  logic                         unused_low;

  dwd_regs #(.N_WIN(N_WIN), .REG_AW(REG_AW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .en_o       (en),
    .acc_o      (acc),
    .base_o     (base),
    .mask_o     (mask),
    .attr_o     (attr),
    .ovr_en_o   (ovr_en),
    .ovr_page_o (ovr_page)
  );

  assign page       = ovr_en ? ovr_page : req_addr_i[ADDR_W-1 -: PAGE_W];
  assign unused_low = ^req_addr_i[PAGE_LSB-1:0];

  dwd_win_match #(.N_WIN(N_WIN)) u_match (
    .en_i   (en),
    .base_i (base),
    .mask_i (mask),
    .page_i (page),
    .hit_o  (match)
  );

  dwd_lowest_pick #(.N(N_WIN), .IW(WIN_IW)) u_pick (
    .req_i (match),
    .gnt_o (gnt),
    .idx_o (idx)
  );

  // permission is judged on the winner only; no fall-through
  assign any     = |match;
  assign acc_sel = acc[idx];
  assign perm_ok = req_write_i ? acc_sel[ACC_WR] : acc_sel[ACC_RD];

  always_comb begin
    flags_d.hit  = any &&  perm_ok;
    flags_d.err  = any && !perm_ok;
    flags_d.miss = !any;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      flags_q <= '0;
      win_q   <= '0;
      attr_q  <= '0;
    end else begin
      valid_q <= req_valid_i;
      flags_q <= req_valid_i ? flags_d : '0;
      win_q   <= (req_valid_i && any) ? idx : '0;
      attr_q  <= (req_valid_i && flags_d.hit) ? attr[idx] : '0;
    end
  end

  assign rsp_valid_o = valid_q;
  assign rsp_hit_o   = flags_q.hit;
  assign rsp_miss_o  = flags_q.miss;
  assign rsp_err_o   = flags_q.err;
  assign rsp_win_o   = win_q;
  assign rsp_attr_o  = attr_q;

  a_r10_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  a_r10_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o && !rsp_hit_o && !rsp_miss_o && !rsp_err_o);

  a_r10_one_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $countones({rsp_hit_o, rsp_miss_o, rsp_err_o}) == 1);

  a_r5_gnt_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt) && ((gnt & ~match) == '0));

  a_r5_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt) |-> (((gnt - N_WIN'(1)) & match) == '0));

  a_r6_miss_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_miss_o |-> (rsp_win_o == '0) && (rsp_attr_o == '0));

  a_r7_err_no_attr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> rsp_attr_o == '0);
endmodule

// File: tb/dma_win_decode_tb_top.sv
module dma_win_decode_tb_top;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_err;
  logic [1:0]  rsp_win;
  logic [3:0]  rsp_attr;

  always #(CLK_P/2) clk = ~clk;

  dma_win_decode dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_miss_o(rsp_miss),
    .rsp_err_o(rsp_err), .rsp_win_o(rsp_win), .rsp_attr_o(rsp_attr)
  );

  typedef struct {
    logic [8:0] v;  // {hit, miss, err, win[1:0], attr[3:0]}
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // shadow register model (from R2)
  logic [3:0]       s_en = '0;
  logic [1:0]       s_acc [4];
  logic [15:0]      s_base [4];
  logic [15:0]      s_mask [4];
  logic [3:0]       s_attr [4];
  logic             s_oen = 1'b0;
  logic [15:0]      s_opg = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 0) begin
      s_en = d[3:0];
      for (int i = 0; i < 4; i++) s_acc[i] = d[16+2*i +: 2];
    end else if (a == 1) begin
      s_oen = d[0]; s_opg = d[31:16];
    end else if (a <= 9) begin
      if (a[0] == 1'b0) begin
        s_base[(a-2)/2] = d[31:16]; s_attr[(a-2)/2] = d[11:8];
      end else begin
        s_mask[(a-3)/2] = d[31:16];
      end
    end
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  function automatic logic [8:0] model(input logic [31:0] addr, input logic wr);
    logic [15:0] pg;
    pg = s_oen ? s_opg : addr[31:16];
    for (int i = 0; i < 4; i++) begin
      if (s_en[i] && ((pg & ~s_mask[i]) == (s_base[i] & ~s_mask[i]))) begin
        if (wr ? s_acc[i][1] : s_acc[i][0]) return {3'b100, 2'(i), s_attr[i]};
        else                                return {3'b001, 2'(i), 4'h0};
      end
    end
    return {3'b010, 2'b00, 4'h0};
  endfunction

  // driver: leaves the request asserted; call idle() to release
  task automatic send(input logic [31:0] a, input logic wr, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr;
    e.v = model(a, wr); e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic req1(input logic [31:0] a, input logic wr, input string tag);
    send(a, wr, tag);
    idle();
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done && rsp_valid) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R10 unexpected response", 32'(rsp_valid), 32'h0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk({rsp_hit, rsp_miss, rsp_err, rsp_win, rsp_attr} == e.v, e.tag,
            32'({rsp_hit, rsp_miss, rsp_err, rsp_win, rsp_attr}), 32'(e.v));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      s_acc[i] = '0; s_base[i] = '0; s_mask[i] = '0; s_attr[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", 32'(rsp_valid), 0);
    for (int a = 0; a < 10; a++) rd_chk(4'(a), 32'h0, "R1 register reset value");

    // R2: field placement and readback
    wr_reg(0, 32'hFFFF_FFFF); rd_chk(0, 32'h00FF_000F, "R2 control readback");
    wr_reg(1, 32'hFFFF_FFFF); rd_chk(1, 32'hFFFF_0001, "R2 override readback");
    wr_reg(4, 32'hFFFF_FFFF); rd_chk(4, 32'hFFFF_0F00, "R2 base1 readback");
    wr_reg(9, 32'hFFFF_FFFF); rd_chk(9, 32'hFFFF_0000, "R2 mask3 readback");
    wr_reg(1, 32'h0); wr_reg(4, 32'h0); wr_reg(9, 32'h0);

    // R11: unmapped addresses
    for (int a = 10; a < 16; a++) wr_reg(4'(a), 32'hFFFF_FFFF);
    rd_chk(10, 32'h0, "R11 unmapped read zero");
    rd_chk(15, 32'h0, "R11 unmapped read zero");
    rd_chk(0, 32'h00FF_000F, "R11 control untouched");
    rd_chk(4, 32'h0, "R11 base1 untouched");
    rd_chk(1, 32'h0, "R11 override untouched");

    // window setup
    wr_reg(2, 32'h0000_0E00); wr_reg(3, 32'h7FFF_0000);
    wr_reg(4, 32'h8000_0D00); wr_reg(5, 32'h3FFF_0000);
    wr_reg(6, 32'hC000_0B00); wr_reg(7, 32'h0FFF_0000);
    wr_reg(8, 32'h0000_0700); wr_reg(9, 32'hFFFF_0000);
    wr_reg(0, 32'h00FF_0007);
    rd_chk(6, 32'hC000_0B00, "R2 base2 readback");

    // R4, R8: mask matching and attribute
    req1(32'h1234_5678, 1'b0, "R4 win0 match");
    req1(32'h9000_0000, 1'b1, "R8 win1 attr");
    req1(32'hC800_0000, 1'b0, "R4 win2 narrow mask");
    req1(32'hBFFF_FFFF, 1'b0, "R4 win1 upper edge");
    // R6: miss
    req1(32'hD000_0000, 1'b0, "R6 miss");
    req1(32'hFFFF_FFFC, 1'b1, "R6 miss top");

    // R3: enable bits
    wr_reg(0, 32'h00FF_000F);
    req1(32'hD000_0000, 1'b0, "R3 win3 enabled");
    wr_reg(0, 32'h00FF_000E);
    req1(32'h1234_5678, 1'b0, "R3 win0 disabled");

    // R5: overlap, lowest wins
    wr_reg(6, 32'h8000_0B00);
    wr_reg(0, 32'h00FF_0006);
    req1(32'h8100_0000, 1'b0, "R5 win1 over win2");
    wr_reg(0, 32'h00FF_0004);
    req1(32'h8100_0000, 1'b0, "R5 win2 alone");

    // R7: access fields win0=RO win1=WO win2=none win3=RW
    wr_reg(0, 32'h00C9_000F);
    req1(32'h1000_0000, 1'b0, "R7 read on read-only");
    req1(32'h1000_0000, 1'b1, "R7 write on read-only");
    req1(32'h9000_0000, 1'b1, "R7 write on write-only");
    req1(32'h9000_0000, 1'b0, "R7 read on write-only");
    req1(32'h8100_0000, 1'b0, "R7 no fall-through");
    req1(32'hD000_0000, 1'b1, "R7 full access");
    wr_reg(0, 32'h00C9_000D);
    req1(32'h8100_0000, 1'b1, "R7 no-access window");

    // R9: override
    wr_reg(0, 32'h00FF_000F);
    wr_reg(1, 32'hD000_0001);
    req1(32'h1000_0000, 1'b0, "R9 override active");
    wr_reg(1, 32'hD000_0000);
    req1(32'h1000_0000, 1'b0, "R9 override bit clear");
    wr_reg(1, 32'h0);
    req1(32'h9000_0000, 1'b0, "R9 override zero");

    // R10: back-to-back
    send(32'h0000_0000, 1'b0, "R10 burst 0");
    send(32'h8000_0000, 1'b1, "R10 burst 1");
    send(32'hC000_0000, 1'b0, "R10 burst 2");
    send(32'hE000_0000, 1'b1, "R10 burst 3");
    idle();
    repeat (2) @(negedge clk);
    chk(sb_q.size() == 0, "R10 all responses seen", 32'(sb_q.size()), 0);

    finish_run();
  end
endmodule